// File: doc/BRIEF.md
# Configuration Stream Sync and CRC Monitor

This block watches a byte-wide configuration stream that arrives on the configuration clock. Until it finds the 32-bit synchronization pattern, it drops every byte. Once it is locked, it groups the stream into 32-bit words and reads them as packets. A packet can carry payload words, ask for a CRC comparison, or start the startup sequence. The block keeps a running CRC over the payload. It pulls an INIT-style status low only when an explicit comparison fails. It raises DONE after a short phase sequence that runs on a selectable startup clock.

Alignment is never recovered by the block itself. If one byte is lost after lock, every later word is framed wrongly, and no later packet can be decoded. DONE then stays low and the INIT status stays high. Only an abort or a program reset returns the block to the hunt for the sync pattern. The block echoes each decoded header for one cycle. This lets a system see whether word framing still holds.

Top module: `cfg_stream_mon`

## Requirements
- R1: Before the logical word 0xAA995566 has been received, no byte is framed and no header is echoed. The four bytes that follow the pattern form the first word, first byte most significant. The pattern itself is never echoed.
- R2: The pins carry each logical byte reversed: data_i[0] holds bit 7 and data_i[7] holds bit 0. A stream that is not reversed never achieves lock.
- R3: A header's opcode is bits 31:29. 3'b001 means payload follows, and bits 10:0 give the number of payload words (0 means none). 3'b010 means one expected-CRC word follows. 3'b011 means start. Every other opcode is a no-op. Payload words and CRC words are never read as headers.
- R4: The CRC is CRC-16 with polynomial 0x8005 and an initial value of 0. It covers every payload word, bit 31 first, and is cleared while hunting. On a CRC-check packet, bits 15:0 of the expected word are compared with the CRC. A mismatch drives init_o low, and init_o stays low until abort or program reset.
- R5: If no CRC-check packet is decoded, init_o stays high, even after payload data and a start.
- R6: If a byte is lost after lock, the block stays locked on the wrong framing. The echoed headers show the shifted words. With no abort or program reset, a start or check packet in that stream raises neither done_o nor a low init_o.
- R7: abort_i or prog_i, sampled high on a clock edge, returns the block to hunting. After that edge init_o is high, done_o is low and hdr_vld_o is low.
- R8: A start packet arms a 4-phase counter. The counter advances one phase per tick of the selected startup clock. done_o goes high in phase 3 and holds until abort or program reset.
- R9: startup_sel_i selects the startup clock: 0 for the configuration clock, 1 for jtag_clk_i, 2 for user_clk_i, and 3 acts as 0. The block samples it only while hunting. A change after lock has no effect.
- R10: If the selected external startup clock does not toggle, done_o stays low. Once that clock toggles, done_o rises.
- R11: Each decoded header appears on hdr_o with hdr_vld_o high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Stream byte, bit-reversed on the pins |
| data_vld_i | input | 1 | Byte strobe |
| abort_i | input | 1 | Parallel-port abort, back to hunting |
| prog_i | input | 1 | Program reset, back to hunting |
| startup_sel_i | input | 2 | Startup clock select |
| jtag_clk_i | input | 1 | JTAG clock used as a startup source |
| user_clk_i | input | 1 | User clock used as a startup source |
| init_o | output | 1 | High while no check has failed |
| done_o | output | 1 | Startup finished |
| hdr_o | output | 32 | Last decoded header |
| hdr_vld_o | output | 1 | One-cycle strobe for hdr_o |

## Verification
A framing or lock error shows up on hdr_o at once. The header echo of the very next word is shifted or missing, so a scoreboard of expected headers catches it within four bytes. A wrong CRC state stays hidden until a check packet arrives. At that point init_o is wrong one cycle after the check word's last byte. A wrong startup state shows as done_o missing, or rising too early, within a few ticks of the selected clock. A stale clock selection shows as done_o rising while the external clock is idle.

// File: rtl/cfg_mon_pkg.sv
package cfg_mon_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CRC_W  = 16;
  localparam int unsigned LEN_W  = 11;
  localparam logic [31:0] SYNC_PATTERN = 32'hAA995566;
  localparam logic [15:0] CRC_POLY     = 16'h8005;

  localparam logic [2:0] OP_WRITE = 3'b001;
  localparam logic [2:0] OP_CHECK = 3'b010;
  localparam logic [2:0] OP_START = 3'b011;

  typedef enum logic [1:0] {
    PK_HDR   = 2'd0,
    PK_DATA  = 2'd1,
    PK_CHECK = 2'd2
  } pk_state_e;

  typedef enum logic [1:0] {
    SU_CFG  = 2'd0,
    SU_JTAG = 2'd1,
    SU_USER = 2'd2,
    SU_ALT  = 2'd3
  } su_sel_e;
endpackage

// File: rtl/cfg_word_asm.sv
module cfg_word_asm #(
  parameter int unsigned BYTE_W = cfg_mon_pkg::BYTE_W,
  parameter int unsigned WORD_W = cfg_mon_pkg::WORD_W,
  parameter logic [WORD_W-1:0] SYNC = cfg_mon_pkg::SYNC_PATTERN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              synced_o,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned BPW   = WORD_W / BYTE_W;
  localparam int unsigned CNT_W = $clog2(BPW);
  localparam int unsigned HIST_W = WORD_W - BYTE_W;

  logic [BYTE_W-1:0] byte_rev;
  logic [HIST_W-1:0] hist_q;
  logic [WORD_W-1:0] win_nxt;
  logic [CNT_W-1:0]  cnt_q;

  // pin 0 carries the logical MSB
  for (genvar g = 0; g < BYTE_W; g++) begin : g_rev
    assign byte_rev[g] = byte_i[BYTE_W-1-g];
  end

  assign win_nxt = {hist_q, byte_rev};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q     <= '0;
      cnt_q      <= '0;
      synced_o   <= 1'b0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else begin
      word_vld_o <= 1'b0;
      if (clr_i) begin
        hist_q   <= '0;
        cnt_q    <= '0;
        synced_o <= 1'b0;
      end else if (byte_vld_i) begin
        hist_q <= win_nxt[HIST_W-1:0];
        if (!synced_o) begin
          if (win_nxt == SYNC) begin
            synced_o <= 1'b1;
            cnt_q    <= '0;
          end
        end else if (cnt_q == CNT_W'(BPW-1)) begin
          word_o     <= win_nxt;
          word_vld_o <= 1'b1;
          cnt_q      <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_word_after_sync_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> synced_o);

  // no self-recovery once locked
  p_lock_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (synced_o && !clr_i) |=> synced_o);
endmodule

// File: rtl/cfg_crc16.sv
module cfg_crc16 #(
  parameter int unsigned DATA_W = cfg_mon_pkg::WORD_W,
  parameter int unsigned CRC_W  = cfg_mon_pkg::CRC_W,
  parameter logic [CRC_W-1:0] POLY = cfg_mon_pkg::CRC_POLY
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  always_comb begin
    logic [CRC_W-1:0] c;
    logic fb;
    c = crc_i;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ data_i[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    crc_o = c;
  end
endmodule

// File: rtl/cfg_startup.sv
module cfg_startup #(
  parameter int unsigned PHASES      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       start_i,
  input  logic [1:0] sel_i,
  input  logic       jtag_clk_i,
  input  logic       user_clk_i,
  output logic       done_o
);
  import cfg_mon_pkg::*;

  localparam int unsigned PH_W    = $clog2(PHASES);
  localparam int unsigned DONE_PH = PHASES - 1;
  localparam int unsigned N_EXT   = 2;

  logic [N_EXT-1:0] ext_clk;
  logic [N_EXT-1:0] ext_rise;
  logic             tick;
  logic             active_q;
  logic [PH_W-1:0]  phase_q;

  assign ext_clk = {user_clk_i, jtag_clk_i};

  // external clocks are slower than clk_i; sample and edge-detect
  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    logic [SYNC_STAGES:0] s_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) s_q <= '0;
      else         s_q <= {s_q[SYNC_STAGES-1:0], ext_clk[g]};
    end
    assign ext_rise[g] = s_q[SYNC_STAGES-1] & ~s_q[SYNC_STAGES];
  end

  always_comb begin
    unique case (su_sel_e'(sel_i))
      SU_JTAG: tick = ext_rise[0];
      SU_USER: tick = ext_rise[1];
      default: tick = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= '0;
    end else if (clr_i) begin
      active_q <= 1'b0;
      phase_q  <= '0;
    end else begin
      if (start_i) active_q <= 1'b1;
      if (active_q && tick && phase_q != PH_W'(DONE_PH)) phase_q <= phase_q + 1'b1;
    end
  end

  assign done_o = active_q && (phase_q == PH_W'(DONE_PH));

  p_done_on_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(tick));

  p_stall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !tick) |=> $stable(phase_q));
endmodule

// File: rtl/cfg_stream_mon.sv
module cfg_stream_mon #(
  parameter int unsigned LEN_W = cfg_mon_pkg::LEN_W
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  data_i,
  input  logic        data_vld_i,
  input  logic        abort_i,
  input  logic        prog_i,
  input  logic [1:0]  startup_sel_i,
  input  logic        jtag_clk_i,
  input  logic        user_clk_i,
  output logic        init_o,
  output logic        done_o,
  output logic [31:0] hdr_o,
  output logic        hdr_vld_o
);
  import cfg_mon_pkg::*;

  logic              clr;
  logic              synced;
  logic              word_vld;
  logic [WORD_W-1:0] word;
  logic [CRC_W-1:0]  crc_q;
  logic [CRC_W-1:0]  crc_nxt;
  logic [LEN_W-1:0]  rem_q;
  logic              fail_q;
  logic              start_q;
  logic [1:0]        sel_q;
  pk_state_e         state_q;

  assign clr = abort_i | prog_i;

  cfg_word_asm #(
    .BYTE_W(BYTE_W),
    .WORD_W(WORD_W),
    .SYNC  (SYNC_PATTERN)
  ) u_asm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .byte_vld_i(data_vld_i),
    .byte_i    (data_i),
    .synced_o  (synced),
    .word_vld_o(word_vld),
    .word_o    (word)
  );

  cfg_crc16 #(
    .DATA_W(WORD_W),
    .CRC_W (CRC_W),
    .POLY  (CRC_POLY)
  ) u_crc (
    .crc_i (crc_q),
    .data_i(word),
    .crc_o (crc_nxt)
  );

  // selection frozen once locked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sel_q <= SU_CFG;
    else if (clr || !synced)    sel_q <= startup_sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= PK_HDR;
      rem_q     <= '0;
      crc_q     <= '0;
      fail_q    <= 1'b0;
      start_q   <= 1'b0;
      hdr_o     <= '0;
      hdr_vld_o <= 1'b0;
    end else begin
      hdr_vld_o <= 1'b0;
      start_q   <= 1'b0;
      if (clr) begin
        state_q <= PK_HDR;
        rem_q   <= '0;
        crc_q   <= '0;
        fail_q  <= 1'b0;
        hdr_o   <= '0;
      end else if (!synced) begin
        state_q <= PK_HDR;
        crc_q   <= '0;
      end else if (word_vld) begin
        unique case (state_q)
          PK_HDR: begin
            hdr_o     <= word;
            hdr_vld_o <= 1'b1;
            unique case (word[31:29])
              OP_WRITE: if (word[LEN_W-1:0] != '0) begin
                rem_q   <= word[LEN_W-1:0];
                state_q <= PK_DATA;
              end
              OP_CHECK: state_q <= PK_CHECK;
              OP_START: start_q <= 1'b1;
              default: ;
            endcase
          end
          PK_DATA: begin
            crc_q <= crc_nxt;
            rem_q <= rem_q - 1'b1;
            if (rem_q == LEN_W'(1)) state_q <= PK_HDR;
          end
          PK_CHECK: begin
            if (word[CRC_W-1:0] != crc_q) fail_q <= 1'b1;
            state_q <= PK_HDR;
          end
          default: state_q <= PK_HDR;
        endcase
      end
    end
  end

  assign init_o = ~fail_q;

  cfg_startup #(
    .PHASES     (4),
    .SYNC_STAGES(2)
  ) u_startup (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .start_i   (start_q),
    .sel_i     (sel_q),
    .jtag_clk_i(jtag_clk_i),
    .user_clk_i(user_clk_i),
    .done_o    (done_o)
  );

  p_init_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(init_o) |-> $past(state_q == PK_CHECK && word_vld));

  p_init_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_o && !clr) |=> !init_o);

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (init_o && !done_o && !hdr_vld_o));

  p_sel_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (synced && !clr) |=> $stable(sel_q));

  p_hdr_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_vld_o |=> !hdr_vld_o);
endmodule

// File: tb/cfg_stream_mon_tb.sv
module cfg_stream_mon_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  data = '0;
  logic        data_vld = 1'b0;
  logic        abort = 1'b0;
  logic        prog = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic        jtag_clk = 1'b0;
  logic        user_clk = 1'b0;
  logic        init;
  logic        done;
  logic [31:0] hdr;
  logic        hdr_vld;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_stream_mon u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .data_i       (data),
    .data_vld_i   (data_vld),
    .abort_i      (abort),
    .prog_i       (prog),
    .startup_sel_i(sel),
    .jtag_clk_i   (jtag_clk),
    .user_clk_i   (user_clk),
    .init_o       (init),
    .done_o       (done),
    .hdr_o        (hdr),
    .hdr_vld_o    (hdr_vld)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c0, input logic [31:0] d);
    logic [15:0] c = c0;
    for (int i = 31; i >= 0; i--) begin
      if (c[15] ^ d[i]) c = {c[14:0], 1'b0} ^ 16'h8005;
      else              c = {c[14:0], 1'b0};
    end
    return c;
  endfunction

  // monitor: compare each echoed header against the scoreboard
  always @(negedge clk) begin
    if (rst_n && hdr_vld) begin
      if (exp_q.size() == 0) chk(1'b0, "R11 unexpected header", hdr, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(hdr == e, "R3 header echo", hdr, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic send_pin(input logic [7:0] pins);
    data = pins; data_vld = 1'b1;
    @(posedge clk); #1;
    data_vld = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    send_pin(r);
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 3; i >= 0; i--) send_byte(w[i*8 +: 8]);
  endtask

  task automatic send_hdr(input logic [31:0] w);
    exp_q.push_back(w);
    send_word(w);
  endtask

  task automatic pulse_prog();
    prog = 1'b1; tick(1); prog = 1'b0;
  endtask

  task automatic toggle_ext(input bit user, input int n);
    for (int i = 0; i < n; i++) begin
      if (user) user_clk = 1'b1; else jtag_clk = 1'b1;
      tick(4);
      if (user) user_clk = 1'b0; else jtag_clk = 1'b0;
      tick(4);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    finish_test();
  end

  initial begin
    logic [15:0] c;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk(init === 1'b1, "R7 reset init", {31'h0, init}, 32'h1);
    chk(done === 1'b0, "R7 reset done", {31'h0, done}, 32'h0);
    chk(hdr_vld === 1'b0, "R11 reset strobe", {31'h0, hdr_vld}, 32'h0);

    // R1: junk, partial pattern, then lock; payload and correct check
    send_byte(8'h12); send_byte(8'hAA); send_byte(8'h99);
    send_hdr(32'h6000_0000); // before lock: not echoed
    exp_q.pop_back();
    send_word(32'hAA99_5566);
    send_hdr(32'h2000_0002);
    send_word(32'h1234_5678);
    send_word(32'h9ABC_DEF0);
    c = ref_crc(16'h0, 32'h1234_5678);
    c = ref_crc(c, 32'h9ABC_DEF0);
    send_hdr(32'h4000_0000);
    send_word({16'h0, c});
    tick(3);
    chk(init === 1'b1, "R4 matching CRC keeps init", {31'h0, init}, 32'h1);
    chk(done === 1'b0, "R8 no done before start", {31'h0, done}, 32'h0);
    send_hdr(32'h6000_0000);
    tick(10);
    chk(done === 1'b1, "R8 done on config clock", {31'h0, done}, 32'h1);
    chk(exp_q.size() == 0, "R1 all headers echoed", exp_q.size(), 32'h0);

    // R4: mismatch pulls init low, sticky; R7 abort clears
    pulse_prog();
    chk(done === 1'b0 && init === 1'b1, "R7 prog clears", {30'h0, done, init}, 32'h1);
    send_word(32'hAA99_5566);
    send_hdr(32'h2000_0001);
    send_word(32'hCAFE_F00D);
    c = ref_crc(16'h0, 32'hCAFE_F00D);
    send_hdr(32'h4000_0000);
    send_word({16'h0, c ^ 16'h0001});
    tick(1);
    chk(init === 1'b0, "R4 mismatch drives init low", {31'h0, init}, 32'h0);
    send_hdr(32'hE000_0000); // no-op opcode
    tick(5);
    chk(init === 1'b0, "R4 init stays low", {31'h0, init}, 32'h0);
    abort = 1'b1; tick(1); abort = 1'b0;
    chk(init === 1'b1 && hdr_vld === 1'b0, "R7 abort clears init", {31'h0, init}, 32'h1);
    // relock after abort
    send_word(32'hAA99_5566);
    send_hdr(32'h6000_0000);
    tick(10);
    chk(done === 1'b1, "R7 relock after abort", {31'h0, done}, 32'h1);

    // R5: payload and start without check
    pulse_prog();
    send_word(32'hAA99_5566);
    send_hdr(32'h2000_0001);
    send_word(32'h6000_0000); // payload that looks like start: not a header (R3)
    tick(10);
    chk(done === 1'b0, "R3 payload not decoded", {31'h0, done}, 32'h0);
    send_hdr(32'h6000_0000);
    tick(10);
    chk(init === 1'b1 && done === 1'b1, "R5 no check keeps init high", {30'h0, init, done}, 32'h3);

    // R2: unreversed pattern does not lock
    pulse_prog();
    send_pin(8'hAA); send_pin(8'h99); send_pin(8'h55); send_pin(8'h66);
    send_word(32'h6000_0000);
    tick(10);
    chk(done === 1'b0, "R2 unreversed stream ignored", {31'h0, done}, 32'h0);

    // R6: one byte lost after lock
    pulse_prog();
    send_word(32'hAA99_5566);
    exp_q.push_back(32'h0000_00DE);
    exp_q.push_back(32'hADBE_EF60);
    exp_q.push_back(32'h0000_0000);
    send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
    send_word(32'hDEAD_BEEF);
    send_word(32'h6000_0000);
    send_word(32'h0000_0000);
    tick(10);
    chk(done === 1'b0, "R6 misaligned start ignored", {31'h0, done}, 32'h0);
    chk(init === 1'b1, "R6 misaligned check never fails", {31'h0, init}, 32'h1);
    chk(exp_q.size() == 0, "R6 shifted headers echoed", exp_q.size(), 32'h0);

    // R9/R10: JTAG select taken while hunting, later change ignored
    pulse_prog();
    sel = 2'd1;
    tick(2);
    send_word(32'hAA99_5566);
    sel = 2'd0;
    send_hdr(32'h6000_0000);
    tick(20);
    chk(done === 1'b0, "R10 idle JTAG clock stalls", {31'h0, done}, 32'h0);
    chk(done === 1'b0, "R9 select frozen after lock", {31'h0, done}, 32'h0);
    toggle_ext(1'b0, 5);
    chk(done === 1'b1, "R10 JTAG clock completes", {31'h0, done}, 32'h1);

    // R8: user clock
    pulse_prog();
    sel = 2'd2;
    tick(2);
    send_word(32'hAA99_5566);
    send_hdr(32'h6000_0000);
    tick(20);
    chk(done === 1'b0, "R8 user clock idle", {31'h0, done}, 32'h0);
    toggle_ext(1'b1, 5);
    chk(done === 1'b1, "R8 user clock completes", {31'h0, done}, 32'h1);

    tick(5);
    chk(exp_q.size() == 0, "R11 scoreboard drained", exp_q.size(), 32'h0);
    finish_test();
  end
endmodule